// File: doc/BRIEF.md
# Audio Serial Clock Ratio Generator

This block derives the clocks of a stereo audio serial link from one system clock. A source event arrives either on every system clock cycle or on each cycle in which a separate audio-rate strobe is high. The source can be thinned by an optional integer prescaler. Each surviving event becomes a one-cycle root clock enable, which downstream logic uses as the codec master clock. The block counts root ticks to build a frame of 256, 384, 512 or 768 ticks. From that frame count it produces a bit clock with 16, 32 or 48 periods per frame, chosen by the sample width. It also produces a left/right clock that is low for the first half of each frame and high for the second half.

In the two slave modes, no clocks are generated. The bit clock and left/right clock outputs repeat the external pins, and the root clock enable stays low. A new ratio, width or mode takes effect only when a frame ends, so the outputs never carry a shortened or stretched period. The only exception is leaving slave mode, which takes effect on the next clock. Shifting of the sample data is left to a neighbouring block.

Top module: `aclk_ratio_gen`

## Requirements
- R1: While `rst_n` is low, `rclk_en`, `bclk` and `lrclk` are 0 from the first clock edge on, and the ratio, width and mode inputs present during reset form the active configuration.
- R2: With `psr_en` = 1, `rclk_en` pulses once for every `psr_val`+1 source events. With `psr_en` = 0, it pulses once per source event and `psr_val` has no effect.
- R3: `mode_sel[0]` = 0 makes every clock cycle a source event, and `aclk_tick` is then ignored. `mode_sel[0]` = 1 makes each cycle with `aclk_tick` high a source event. Each `rclk_en` pulse follows its source event by one cycle.
- R4: A frame lasts 256, 384, 512 or 768 `rclk_en` pulses for `rfs_sel` = 00, 01, 10 or 11 respectively.
- R5: Each frame holds 16 rising edges of `bclk` for `width_sel` = 00 (8-bit samples), 32 for 01 (16-bit), 48 for 10 (24-bit), and 32 for the spare code 11. In master mode, `bclk` changes only in the cycle after an `rclk_en` pulse.
- R6: `lrclk` is low for the first half of the frame's `rclk_en` pulses and high for the second half. A frame begins where `lrclk` falls, and `bclk` is low there.
- R7: In master mode, a change of `rfs_sel`, `width_sel` or `mode_sel` has no effect until the frame in progress has completed.
- R8: With `mode_sel[1]` = 1 (slave), `bclk` follows `ext_bclk`, `lrclk` follows `ext_lrclk`, and `rclk_en` stays low. A mode change made while in slave mode takes effect on the next clock edge, and the first cycle back in master mode has no `rclk_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aclk_tick | input | 1 | Audio-rate source strobe, used when `mode_sel[0]` = 1 |
| psr_en | input | 1 | Prescaler enable |
| psr_val | input | PSR_W | Prescaler value; divide by value plus one |
| rfs_sel | input | 2 | Root ticks per frame: 00=256, 01=384, 10=512, 11=768 |
| width_sel | input | 2 | Sample width: 00=8, 01=16, 10=24, 11=16 |
| mode_sel | input | 2 | Bit 1: slave; bit 0: audio strobe as source |
| ext_bclk | input | 1 | External bit clock, passed through in slave mode |
| ext_lrclk | input | 1 | External left/right clock, passed through in slave mode |
| rclk_en | output | 1 | Root clock enable, one cycle per root tick |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Left/right frame clock |

## Verification
A configuration request can arrive in the same cycle as the frame-closing root tick that applies it, so latching and wrapping must agree. This is provoked by requesting slave mode right at a frame start and counting the root pulses still issued, which must equal one whole frame of the old ratio. A ratio and width change is also made fifty ticks into a frame. That frame must keep its old length, and the following frames must show the new tick and bit-edge counts.

// File: rtl/aclk_pkg.sv
// Shared types and ratio decoders for the audio clock ratio generator.
// Assumes ratios of at most 768 root ticks per frame and 48 bit periods.
package aclk_pkg;
    localparam int RATIO_W = 10;
    localparam int ACC_W   = RATIO_W + 1;
    localparam int BPF_W   = 7;

    typedef enum logic [1:0] {
        RFS_256 = 2'b00,
        RFS_384 = 2'b01,
        RFS_512 = 2'b10,
        RFS_768 = 2'b11
    } rfs_e;

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_24  = 2'b10,
        WID_RSV = 2'b11
    } wid_e;

    typedef struct packed {
        logic slave;
        logic aud_src;
    } mode_t;

    // Root ticks per frame for a ratio code
    function automatic logic [RATIO_W-1:0] root_ratio(rfs_e sel);
        case (sel)
            RFS_384: return RATIO_W'(384);
            RFS_512: return RATIO_W'(512);
            RFS_768: return RATIO_W'(768);
            default: return RATIO_W'(256);
        endcase
    endfunction

    // Bit clock periods per frame for a width code
    function automatic logic [BPF_W-1:0] bits_per_frame(wid_e sel);
        case (sel)
            WID_8:   return BPF_W'(16);
            WID_24:  return BPF_W'(48);
            default: return BPF_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/aclk_prescaler.sv
// Integer prescaler: turns source events into root ticks, one per
// psr_val+1 events when enabled, one per event when bypassed.
// Assumes psr_val may change at any time; the count wraps on >=.
module aclk_prescaler #(
    parameter int PSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_evt,
    input  logic             psr_en,
    input  logic [PSR_W-1:0] psr_val,
    output logic             root_tick
);
    logic [PSR_W-1:0] cnt_q;
    logic             tick_q;
    logic             fire;

    // Decide whether this source event closes a prescaler period
    always_comb begin
        fire = run && src_evt && (!psr_en || (cnt_q >= psr_val));
    end

    // Count source events inside the current prescaler period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !psr_en) begin
            cnt_q <= '0;
        end else if (src_evt) begin
            cnt_q <= fire ? '0 : cnt_q + 1'b1;
        end
    end

    // Register the tick so it is one clean cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= fire;
        end
    end

    assign root_tick = tick_q && run;
endmodule

// File: rtl/aclk_frame_gen.sv
// Frame sequencer: counts root ticks per frame, builds the bit clock
// with a fractional accumulator and the half-frame left/right clock.
// Ratio and width are reloaded only at frame wrap, in reset or idle.
module aclk_frame_gen
    import aclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic root_tick,
    input  logic idle,
    input  rfs_e rfs_in,
    input  wid_e wid_in,
    output logic bclk_q,
    output logic lr_q,
    output logic wrap
);
    rfs_e               rfs_act;
    wid_e               wid_act;
    logic [RATIO_W-1:0] pos_q;
    logic [RATIO_W-1:0] pos_inc;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half;
    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   acc_sum;
    logic [ACC_W-1:0]   acc_nxt;
    logic               bit_edge;
    logic               last;

    // Frame position, bit-edge decision and accumulator update
    always_comb begin
        ratio    = root_ratio(rfs_act);
        half     = ratio >> 1;
        pos_inc  = pos_q + 1'b1;
        last     = (pos_inc == ratio);
        wrap     = root_tick && last;
        acc_sum  = acc_q + ACC_W'({bits_per_frame(wid_act), 1'b0});
        bit_edge = (acc_sum >= {1'b0, ratio});
        acc_nxt  = bit_edge ? (acc_sum - {1'b0, ratio}) : acc_sum;
    end

    // Advance frame state on every root tick
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            pos_q  <= '0;
            acc_q  <= '0;
            bclk_q <= 1'b0;
            lr_q   <= 1'b0;
        end else if (root_tick) begin
            pos_q  <= last ? '0 : pos_inc;
            acc_q  <= acc_nxt;
            bclk_q <= bclk_q ^ bit_edge;
            lr_q   <= !last && (pos_inc >= half);
        end
    end

    // Take a new ratio and width only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n || idle || wrap) begin
            rfs_act <= rfs_in;
            wid_act <= wid_in;
        end
    end
endmodule

// File: rtl/aclk_ratio_gen.sv
// Top of the audio clock ratio generator: selects the source, runs the
// prescaler and frame sequencer, and passes external clocks in slave mode.
// Assumes aclk_tick is already synchronous to clk.
module aclk_ratio_gen
    import aclk_pkg::*;
#(
    parameter int PSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aclk_tick,
    input  logic             psr_en,
    input  logic [PSR_W-1:0] psr_val,
    input  logic [1:0]       rfs_sel,
    input  logic [1:0]       width_sel,
    input  logic [1:0]       mode_sel,
    input  logic             ext_bclk,
    input  logic             ext_lrclk,
    output logic             rclk_en,
    output logic             bclk,
    output logic             lrclk
);
    mode_t mode_act;
    logic  slave_act;
    logic  aud_act;
    logic  src_evt;
    logic  root_tick;
    logic  frame_wrap;
    logic  bclk_int;
    logic  lr_int;

    // Hold the mode; reload in reset, while slave, or at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n || slave_act || frame_wrap) begin
            mode_act <= mode_t'(mode_sel);
        end
    end

    assign slave_act = mode_act.slave;
    assign aud_act   = mode_act.aud_src;

    // Pick the source event stream
    always_comb begin
        src_evt = aud_act ? aclk_tick : 1'b1;
    end

    aclk_prescaler #(
        .PSR_W (PSR_W)
    ) u_psr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!slave_act),
        .src_evt   (src_evt),
        .psr_en    (psr_en),
        .psr_val   (psr_val),
        .root_tick (root_tick)
    );

    aclk_frame_gen u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .root_tick (root_tick),
        .idle      (slave_act),
        .rfs_in    (rfs_e'(rfs_sel)),
        .wid_in    (wid_e'(width_sel)),
        .bclk_q    (bclk_int),
        .lr_q      (lr_int),
        .wrap      (frame_wrap)
    );

    assign rclk_en = root_tick;
    assign bclk    = slave_act ? ext_bclk  : bclk_int;
    assign lrclk   = slave_act ? ext_lrclk : lr_int;
endmodule

// File: rtl/aclk_ratio_gen_chk.sv
// Property checker for aclk_ratio_gen, attached by bind below.
// Assumes the observed signals are synchronous to clk.
module aclk_ratio_gen_chk #(
    parameter int PSR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aclk_tick,
    input logic             psr_en,
    input logic [PSR_W-1:0] psr_val,
    input logic             rclk_en,
    input logic             bclk,
    input logic             lrclk,
    input logic             slave_act,
    input logic             aud_act
);
    // With a non-zero prescale, two root ticks never sit back to back
    assert_psr_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_en && psr_en && (psr_val != '0) && !slave_act) |=> !rclk_en);

    // With the audio strobe as source, no tick follows a quiet strobe
    assert_aud_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(aud_act) && !$past(aclk_tick)) |-> !rclk_en);

    // In master mode the bit clock moves only after a root tick
    assert_bclk_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_act && !$past(slave_act) && !$stable(bclk)) |-> $past(rclk_en));

    // At a frame start the bit clock is low
    assert_frame_bclk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_act && !$past(slave_act) && $fell(lrclk)) |-> !bclk);

    // First cycle back in master mode carries no root tick
    assert_slave_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slave_act) |-> !rclk_en);
endmodule

bind aclk_ratio_gen aclk_ratio_gen_chk #(.PSR_W(PSR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .aclk_tick (aclk_tick),
    .psr_en    (psr_en),
    .psr_val   (psr_val),
    .rclk_en   (rclk_en),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .slave_act (slave_act),
    .aud_act   (aud_act)
);

// File: tb/aclk_ratio_gen_bench.sv
// Self-checking bench: a vector table of configurations, then directed
// tests for deferred changes and slave pass-through.
module aclk_ratio_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aclk_tick = 1'b0;
    logic       psr_en = 1'b0;
    logic [7:0] psr_val = '0;
    logic [1:0] rfs_sel = '0;
    logic [1:0] width_sel = '0;
    logic [1:0] mode_sel = '0;
    logic       ext_bclk = 1'b0;
    logic       ext_lrclk = 1'b0;
    logic       rclk_en;
    logic       bclk;
    logic       lrclk;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    aclk_ratio_gen #(.PSR_W(8)) u_aclk_ratio_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .aclk_tick (aclk_tick),
        .psr_en    (psr_en),
        .psr_val   (psr_val),
        .rfs_sel   (rfs_sel),
        .width_sel (width_sel),
        .mode_sel  (mode_sel),
        .ext_bclk  (ext_bclk),
        .ext_lrclk (ext_lrclk),
        .rclk_en   (rclk_en),
        .bclk      (bclk),
        .lrclk     (lrclk)
    );

    typedef struct packed {
        logic       pen;
        logic [7:0] pval;
        logic [1:0] mode;
        logic [1:0] rfs;
        logic [1:0] wid;
        int         ticks;
        int         bits;
        int         gap;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd5, 2'b00, 2'b00, 2'b00, 256, 16, 1},
        '{1'b1, 8'd0, 2'b00, 2'b01, 2'b01, 384, 32, 1},
        '{1'b1, 8'd2, 2'b00, 2'b10, 2'b10, 512, 48, 3},
        '{1'b0, 8'd0, 2'b01, 2'b11, 2'b11, 768, 32, 3},
        '{1'b1, 8'd1, 2'b01, 2'b00, 2'b10, 256, 48, 6},
        '{1'b1, 8'd3, 2'b00, 2'b11, 2'b01, 768, 32, 4}
    };

    // Audio strobe: high one cycle in every three
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            aclk_tick = 1'b1;
            @(negedge clk);
            aclk_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wait_fall();
        logic pl;
        pl = lrclk;
        forever begin
            @(negedge clk);
            if (pl && !lrclk) break;
            pl = lrclk;
        end
    endtask

    task automatic measure_frame(output int ticks, output int rises, output int lrhi);
        logic pl;
        logic pb;
        ticks = 0;
        rises = 0;
        lrhi  = 0;
        wait_fall();
        forever begin
            ticks += int'(rclk_en);
            if (rclk_en && lrclk) lrhi++;
            pl = lrclk;
            pb = bclk;
            @(negedge clk);
            if (!pb && bclk) rises++;
            if (pl && !lrclk) break;
        end
    endtask

    task automatic measure_gap(output int n);
        while (!rclk_en) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rclk_en);
    endtask

    initial begin
        int ticks;
        int rises;
        int lrhi;
        int gap;
        int cnt;
        logic pl;

        // Vector table: each configuration loaded through reset
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rst_n     = 1'b0;
            psr_en    = VECS[i].pen;
            psr_val   = VECS[i].pval;
            mode_sel  = VECS[i].mode;
            rfs_sel   = VECS[i].rfs;
            width_sel = VECS[i].wid;
            repeat (3) @(negedge clk);
            check("R1 rclk_en in reset", int'(rclk_en), 0);
            check("R1 bclk/lrclk in reset", int'({bclk, lrclk}), 0);
            rst_n = 1'b1;
            measure_gap(gap);
            check("R2 R3 tick spacing", gap, VECS[i].gap);
            measure_frame(ticks, rises, lrhi);
            check("R4 ticks per frame", ticks, VECS[i].ticks);
            check("R5 bclk rises per frame", rises, VECS[i].bits);
            check("R6 ticks with lrclk high", lrhi, VECS[i].ticks / 2);
        end

        // R7: ratio and width change mid-frame is deferred
        @(negedge clk);
        rst_n     = 1'b0;
        psr_en    = 1'b0;
        mode_sel  = 2'b00;
        rfs_sel   = 2'b00;
        width_sel = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_fall();
        cnt = 0;
        forever begin
            cnt += int'(rclk_en);
            pl = lrclk;
            if (cnt == 50) begin
                rfs_sel   = 2'b10;
                width_sel = 2'b00;
            end
            @(negedge clk);
            if (pl && !lrclk) break;
        end
        check("R7 frame with pending change keeps old length", cnt, 256);
        measure_frame(ticks, rises, lrhi);
        check("R7 new ratio after boundary", ticks, 512);
        check("R7 new width after boundary", rises, 16);

        // R7/R8: slave request at frame start waits for the frame to end
        wait_fall();
        mode_sel = 2'b10;
        cnt = 0;
        while (rclk_en) begin
            cnt++;
            @(negedge clk);
        end
        check("R7 ticks before slave entry", cnt, 512);

        // R8: pass-through of external clocks
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ext_bclk  = k[0];
            ext_lrclk = k[1];
            #1;
            check("R8 bclk follows ext_bclk", int'(bclk), k & 1);
            check("R8 lrclk follows ext_lrclk", int'(lrclk), (k >> 1) & 1);
        end
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cnt += int'(rclk_en);
        end
        check("R8 no root ticks in slave", cnt, 0);

        // R8: leaving slave is immediate and restarts from a frame start
        rfs_sel   = 2'b00;
        width_sel = 2'b10;
        mode_sel  = 2'b00;
        @(negedge clk);
        check("R8 lrclk low after leaving slave", int'(lrclk), 0);
        measure_frame(ticks, rises, lrhi);
        check("R8 master frame after slave", ticks, 256);
        check("R5 24-bit rises after slave", rises, 48);

        finish_run();
    end
endmodule